// File: doc/BRIEF.md
# Prescaled Timer/Counter with Match and Capture

This block is a 32-bit timer/counter for a peripheral clock domain. In timer mode a prescaler divides the clock, and the main counter advances once per prescaler wrap. In event mode the counter instead steps on chosen edges of one of the capture inputs. Four compare lanes watch the counter. Each lane can raise a pending flag, reload the counter to zero, or halt it, and each also drives one output pin with its own action. Four capture lanes copy the counter value into a register when their input shows an enabled edge.

Software reaches every setting and result through a small synchronous register bus. A write takes effect on the clock edge where the write strobe is high. Read data is registered and appears one cycle after the address. The capture inputs are asynchronous, so each one passes through a two-flop synchronizer before any edge detection. All pending flags are combined into one interrupt line.

Top module: `evt_timer`

Register word addresses: 0 control (bit0 run enable, bit1 hold-in-reset); 1 mode (bits[1:0] source: 0 clock ticks, 1 rising, 2 falling, 3 both edges; bits[4:2] index of the capture input used as count source); 2 prescale limit; 3 prescale count (read only); 4 counter (read only); 5 pending flags; 6 compare actions; 7 pin register (bits[3:0] pin levels, action of lane i at bits[9+2i:8+2i]); 8 capture actions; 16+i compare value of lane i; 24+j capture value of lane j (read only).

## Requirements
- R1: In timer mode the prescale count runs from 0 up to the prescale limit PR and then wraps to 0 on the next clock. The counter steps by one on that wrap, so it reaches compare value M exactly (PR+1)*M clocks after the run enable is written.
- R2: While control bit1 is 1, the counter and the prescale count are held at 0. While control bit0 is 0, both keep their values.
- R3: Compare action bit 3i+2 (stop) is lane i's halt action. When lane i has it set and the counter steps onto lane i's compare value, the run enable clears. The counter then keeps that value and the prescale count reads 0.
- R4: Compare action bit 3i+1 (reload) is lane i's reload action. While the counter equals lane i's value and that lane has reload set, the next step loads 0 instead of value+1. With PR and compare value M this gives a flag period of (PR+1)*(M+1) clocks.
- R5: Pending flags sit at bits[3:0] for the compare lanes and bits[7:4] for the capture lanes. A compare flag sets only when action bit 3i (notify) is 1. Writing 1 to a flag bit clears it, and a flag that is set in the same cycle stays set. The irq output is 1 exactly when any flag is pending.
- R6: When lane i's compare event fires, its pin follows the 2-bit action: 0 keep, 1 drive low, 2 drive high, 3 invert. Writing the pin register loads the pin levels.
- R7: Capture lane j loads the counter value on a synchronized rising edge when capture action bit 3j is 1, and on a falling edge when bit 3j+1 is 1. Edges that are not enabled leave the capture register unchanged. The capture flag sets only when bit 3j+2 is 1.
- R8: In event mode the counter steps once per selected edge of the chosen capture input, and the prescale count stays at 0.
- R9: After reset, the control, counter, flags, irq and pins are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| cap_in | input | 4 | Asynchronous capture and event inputs |
| match_out | output | 4 | Compare-driven output pins |
| irq | output | 1 | OR of all pending flags |

## Verification
The bench uses the default parameters: a 32-bit counter with four compare lanes and four capture lanes. A table of small prescale limits and compare values makes exact compare latencies countable to the clock, which tests the (PR+1)*M relation for several divider ratios. With a compare value of 0 plus reload, a flag event fires on every clock, so the case where a clear and a set meet in one cycle can be checked. A stopped counter gives known values for the capture and pin checks.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam logic [4:0] A_CTRL       = 5'd0;
    localparam logic [4:0] A_MODE       = 5'd1;
    localparam logic [4:0] A_PSLIM      = 5'd2;
    localparam logic [4:0] A_PSCNT      = 5'd3;
    localparam logic [4:0] A_COUNT      = 5'd4;
    localparam logic [4:0] A_FLAGS      = 5'd5;
    localparam logic [4:0] A_MCTL       = 5'd6;
    localparam logic [4:0] A_PIN        = 5'd7;
    localparam logic [4:0] A_CCTL       = 5'd8;
    localparam logic [4:0] A_MATCH_BASE = 5'd16;
    localparam logic [4:0] A_CAP_BASE   = 5'd24;

    typedef enum logic [1:0] {
        PIN_KEEP = 2'd0,
        PIN_LOW  = 2'd1,
        PIN_HIGH = 2'd2,
        PIN_FLIP = 2'd3
    } pin_act_e;

    typedef enum logic [1:0] {
        SRC_PCLK = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2,
        SRC_BOTH = 2'd3
    } cnt_src_e;

    // compare lane actions: bit0 notify, bit1 reload, bit2 halt
    typedef struct packed {
        logic stop;
        logic clr;
        logic irq;
    } mact_t;

    // capture lane actions: bit0 rising, bit1 falling, bit2 notify
    typedef struct packed {
        logic irq;
        logic fall;
        logic rise;
    } cact_t;

    function automatic logic pin_apply(pin_act_e act, logic cur);
        case (act)
            PIN_LOW:  return 1'b0;
            PIN_HIGH: return 1'b1;
            PIN_FLIP: return ~cur;
            default:  return cur;
        endcase
    endfunction

    function automatic logic edge_hit(cnt_src_e src, logic r, logic f);
        case (src)
            SRC_RISE: return r;
            SRC_FALL: return f;
            SRC_BOTH: return r | f;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/evt_timer_edge.sv
module evt_timer_edge (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= din;
            s2   <= s1;
            prev <= s2;
        end
    end

    assign rise = s2 & ~prev;
    assign fall = ~s2 & prev;
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         hold,
    input  logic         pclk_mode,
    input  logic         ext_step,
    input  logic [W-1:0] ps_lim,
    input  logic         wrap,
    output logic [W-1:0] tc,
    output logic [W-1:0] pc,
    output logic         tick,
    output logic [W-1:0] tc_nxt
);
    logic ps_done;

    assign ps_done = (pc == ps_lim);
    assign tick    = run && !hold && (pclk_mode ? ps_done : ext_step);
    assign tc_nxt  = wrap ? '0 : tc + W'(1);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            tc <= '0;
            pc <= '0;
        end else if (run) begin
            if (!pclk_mode)
                pc <= '0;
            else if (ps_done)
                pc <= '0;
            else
                pc <= pc + W'(1);
            if (tick)
                tc <= tc_nxt;
        end
    end
endmodule

// File: rtl/evt_timer_lane.sv
module evt_timer_lane
    import evt_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         tick,
    input  logic [W-1:0] tc,
    input  logic [W-1:0] tc_nxt,
    input  logic [W-1:0] cmp,
    input  pin_act_e     act,
    input  logic         pin_cur,
    output logic         at_cmp,
    output logic         event_o,
    output logic         pin_nxt
);
    assign at_cmp  = (tc == cmp);
    assign event_o = tick && (tc_nxt == cmp);
    assign pin_nxt = event_o ? pin_apply(act, pin_cur) : pin_cur;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int W       = 32,
    parameter int N_MATCH = 4,
    parameter int N_CAP   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [4:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_we,
    output logic [31:0]        bus_rdata,
    input  logic [N_CAP-1:0]   cap_in,
    output logic [N_MATCH-1:0] match_out,
    output logic               irq
);
    localparam int NF = N_MATCH + N_CAP;

    // software-visible state
    logic               en, hold;
    cnt_src_e           src;
    logic [2:0]         sel;
    logic [W-1:0]       ps_lim;
    mact_t              mctl  [N_MATCH];
    pin_act_e           pact  [N_MATCH];
    cact_t              cctl  [N_CAP];
    logic [W-1:0]       cmp   [N_MATCH];
    logic [W-1:0]       cap_r [N_CAP];
    logic [NF-1:0]      flags;
    logic [N_MATCH-1:0] pins;

    // datapath
    logic [W-1:0]       tc, pc, tc_nxt;
    logic               tick, ext_step, wrap;
    logic [N_MATCH-1:0] at_v, ev, pins_nxt, stop_v, clr_v;
    logic [N_CAP-1:0]   rise_v, fall_v, cap_ev;
    logic [NF-1:0]      set_v, clr_w;
    logic [31:0]        rd_nxt;

    function automatic logic wr_hit(logic [4:0] a);
        return bus_we && (bus_addr == a);
    endfunction

    genvar gi;
    generate
        for (gi = 0; gi < N_CAP; gi++) begin : g_cap
            evt_timer_edge u_edge (
                .clk (clk),
                .rst (rst),
                .din (cap_in[gi]),
                .rise(rise_v[gi]),
                .fall(fall_v[gi])
            );
            assign cap_ev[gi] = (rise_v[gi] & cctl[gi].rise) |
                                (fall_v[gi] & cctl[gi].fall);
            assign set_v[N_MATCH+gi] = cap_ev[gi] & cctl[gi].irq;
        end
        for (gi = 0; gi < N_MATCH; gi++) begin : g_lane
            evt_timer_lane #(.W(W)) u_lane (
                .tick   (tick),
                .tc     (tc),
                .tc_nxt (tc_nxt),
                .cmp    (cmp[gi]),
                .act    (pact[gi]),
                .pin_cur(pins[gi]),
                .at_cmp (at_v[gi]),
                .event_o(ev[gi]),
                .pin_nxt(pins_nxt[gi])
            );
            assign stop_v[gi] = mctl[gi].stop;
            assign clr_v[gi]  = mctl[gi].clr;
            assign set_v[gi]  = ev[gi] & mctl[gi].irq;
        end
    endgenerate

    always_comb begin
        ext_step = 1'b0;
        for (int j = 0; j < N_CAP; j++)
            if (sel == 3'(j))
                ext_step = edge_hit(src, rise_v[j], fall_v[j]);
    end

    assign wrap = |(at_v & clr_v);

    evt_timer_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (en),
        .hold     (hold),
        .pclk_mode(src == SRC_PCLK),
        .ext_step (ext_step),
        .ps_lim   (ps_lim),
        .wrap     (wrap),
        .tc       (tc),
        .pc       (pc),
        .tick     (tick),
        .tc_nxt   (tc_nxt)
    );

    // control and configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= 1'b0;
            hold   <= 1'b0;
            src    <= SRC_PCLK;
            sel    <= '0;
            ps_lim <= '0;
            for (int i = 0; i < N_MATCH; i++) begin
                mctl[i] <= '0;
                pact[i] <= PIN_KEEP;
                cmp[i]  <= '0;
            end
            for (int j = 0; j < N_CAP; j++)
                cctl[j] <= '0;
        end else begin
            if (wr_hit(A_CTRL)) begin
                en   <= bus_wdata[0];
                hold <= bus_wdata[1];
            end
            if (|(ev & stop_v))
                en <= 1'b0;
            if (wr_hit(A_MODE)) begin
                src <= cnt_src_e'(bus_wdata[1:0]);
                sel <= bus_wdata[4:2];
            end
            if (wr_hit(A_PSLIM))
                ps_lim <= bus_wdata[W-1:0];
            for (int i = 0; i < N_MATCH; i++) begin
                if (wr_hit(A_MCTL))
                    mctl[i] <= bus_wdata[3*i +: 3];
                if (wr_hit(A_PIN))
                    pact[i] <= pin_act_e'(bus_wdata[8+2*i +: 2]);
                if (wr_hit(5'(A_MATCH_BASE + i)))
                    cmp[i] <= bus_wdata[W-1:0];
            end
            for (int j = 0; j < N_CAP; j++)
                if (wr_hit(A_CCTL))
                    cctl[j] <= bus_wdata[3*j +: 3];
        end
    end

    // pins, flags and capture registers
    assign clr_w = wr_hit(A_FLAGS) ? bus_wdata[NF-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins  <= '0;
            flags <= '0;
            for (int j = 0; j < N_CAP; j++)
                cap_r[j] <= '0;
        end else begin
            pins  <= wr_hit(A_PIN) ? bus_wdata[N_MATCH-1:0] : pins_nxt;
            flags <= (flags & ~clr_w) | set_v;
            for (int j = 0; j < N_CAP; j++)
                if (cap_ev[j])
                    cap_r[j] <= tc;
        end
    end

    // registered read port
    always_comb begin
        rd_nxt = '0;
        case (bus_addr)
            A_CTRL:  rd_nxt[1:0] = {hold, en};
            A_MODE:  rd_nxt[4:0] = {sel, src};
            A_PSLIM: rd_nxt[W-1:0] = ps_lim;
            A_PSCNT: rd_nxt[W-1:0] = pc;
            A_COUNT: rd_nxt[W-1:0] = tc;
            A_FLAGS: rd_nxt[NF-1:0] = flags;
            A_MCTL:
                for (int i = 0; i < N_MATCH; i++)
                    rd_nxt[3*i +: 3] = mctl[i];
            A_PIN: begin
                rd_nxt[N_MATCH-1:0] = pins;
                for (int i = 0; i < N_MATCH; i++)
                    rd_nxt[8+2*i +: 2] = pact[i];
            end
            A_CCTL:
                for (int j = 0; j < N_CAP; j++)
                    rd_nxt[3*j +: 3] = cctl[j];
            default: begin
                for (int i = 0; i < N_MATCH; i++)
                    if (bus_addr == 5'(A_MATCH_BASE + i))
                        rd_nxt[W-1:0] = cmp[i];
                for (int j = 0; j < N_CAP; j++)
                    if (bus_addr == 5'(A_CAP_BASE + j))
                        rd_nxt[W-1:0] = cap_r[j];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else
            bus_rdata <= rd_nxt;
    end

    assign match_out = pins;
    assign irq       = |flags;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int W       = 32,
    parameter int N_MATCH = 4,
    parameter int NF      = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [W-1:0]       tc,
    input logic [NF-1:0]      flags,
    input logic               en,
    input logic               hold,
    input logic               bus_we,
    input logic [4:0]         bus_addr,
    input logic [N_MATCH-1:0] ev,
    input logic [N_MATCH-1:0] stop_v,
    input logic [N_MATCH-1:0] pins
);
    // R9: state right after reset release is cleared
    a_r9_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (tc == '0 && flags == '0 && pins == '0 && !en));

    // R2: a disabled, non-held counter keeps its value
    a_r2_freeze: assert property (@(posedge clk) disable iff (rst)
        (!en && !hold) |=> (tc == $past(tc)));

    // R1: the counter only holds, steps by one, or returns to zero
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (!hold) |=> (tc == $past(tc) || tc == $past(tc) + W'(1) || tc == '0));

    // R3: a halting compare event drops the run enable
    a_r3_stop_clears_enable: assert property (@(posedge clk) disable iff (rst)
        (|(ev & stop_v)) |=> !en);

    // R5: pending flags stay set unless the flag register is written
    a_r5_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == A_FLAGS) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind evt_timer evt_timer_chk #(
    .W(W),
    .N_MATCH(N_MATCH),
    .NF(NF)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tc      (tc),
    .flags   (flags),
    .en      (en),
    .hold    (hold),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .ev      (ev),
    .stop_v  (stop_v),
    .pins    (pins)
);

// File: tb/test_evt_timer.sv
module test_evt_timer;
    import evt_timer_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [31:0] bus_rdata;
    logic [3:0]  cap_in;
    logic [3:0]  match_out;
    logic        irq;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    evt_timer i_evt_timer (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_rdata(bus_rdata),
        .cap_in   (cap_in),
        .match_out(match_out),
        .irq      (irq)
    );

    // {prescale limit, compare value, expected clocks = (PR+1)*M}
    localparam logic [95:0] VEC [5] = '{
        {32'd0, 32'd7, 32'd7},
        {32'd1, 32'd4, 32'd8},
        {32'd3, 32'd5, 32'd20},
        {32'd2, 32'd1, 32'd3},
        {32'd0, 32'd1, 32'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic wait_irq(output int at);
        int n = 0;
        while (!irq && n < 2000) begin
            @(negedge clk);
            n++;
        end
        at = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse3(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cap_in[3] = 1'b1;
            idle(3);
            cap_in[3] = 1'b0;
            idle(3);
        end
        idle(5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, a, b;
        int t0, t1, t2;
        rst = 1'b1;
        bus_addr = '0;
        bus_wdata = '0;
        bus_we = 1'b0;
        cap_in = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd(A_CTRL, v);  check("R9 ctrl", v, 0);
        rd(A_COUNT, v); check("R9 count", v, 0);
        rd(A_FLAGS, v); check("R9 flags", v, 0);
        check("R9 irq", 32'(irq), 0);
        check("R9 pins", 32'(match_out), 0);

        // R1 / R3: table of prescale and compare values with halt + notify
        for (int k = 0; k < 5; k++) begin
            wr(A_CTRL, 32'd2);
            wr(A_FLAGS, 32'hFF);
            wr(A_PSLIM, VEC[k][95:64]);
            wr(A_MATCH_BASE, VEC[k][63:32]);
            wr(A_MCTL, 32'b101);
            wr(A_CTRL, 32'd1);
            t0 = cyc;
            wait_irq(t1);
            check("R1 clocks to compare", 32'(t1 - t0), VEC[k][31:0]);
            rd(A_COUNT, v); check("R3 count holds compare value", v, VEC[k][63:32]);
            rd(A_PSCNT, v); check("R3 prescale count zero", v, 0);
            rd(A_CTRL, v);  check("R3 enable cleared", v, 0);
        end

        // R4: reload gives period (PR+1)*(M+1)
        wr(A_CTRL, 32'd2);
        wr(A_FLAGS, 32'hFF);
        wr(A_PSLIM, 32'd1);
        wr(A_MATCH_BASE, 32'd2);
        wr(A_MCTL, 32'b011);
        wr(A_CTRL, 32'd1);
        wait_irq(t1);
        wr(A_FLAGS, 32'h1);
        check("R5 write-one clears flag", 32'(irq), 0);
        wait_irq(t2);
        check("R4 reload period", 32'(t2 - t1), 6);
        rd(A_COUNT, v);
        check("R4 count never passes compare", 32'(v <= 32'd2), 1);

        // R5: set in the same cycle as clear wins
        wr(A_CTRL, 32'd2);
        wr(A_PSLIM, 32'd0);
        wr(A_MATCH_BASE, 32'd0);
        wr(A_CTRL, 32'd1);
        idle(3);
        wr(A_FLAGS, 32'h1);
        rd(A_FLAGS, v); check("R5 set wins over clear", v, 1);
        check("R5 irq with pending flag", 32'(irq), 1);
        wr(A_CTRL, 32'd0);
        wr(A_FLAGS, 32'hFF);
        rd(A_FLAGS, v); check("R5 flags cleared", v, 0);
        check("R5 irq idle", 32'(irq), 0);

        // R6: pin actions keep / invert / high / low
        wr(A_CTRL, 32'd2);
        wr(A_MCTL, 32'h800);
        wr(A_MATCH_BASE + 5'd0, 32'd1);
        wr(A_MATCH_BASE + 5'd1, 32'd1);
        wr(A_MATCH_BASE + 5'd2, 32'd2);
        wr(A_MATCH_BASE + 5'd3, 32'd2);
        wr(A_PIN, 32'h6C09);
        check("R6 pins loaded", 32'(match_out), 32'h9);
        wr(A_CTRL, 32'd1);
        idle(10);
        check("R6 pin actions", 32'(match_out), 32'h7);
        rd(A_COUNT, v); check("R3 halted on lane 3", v, 2);
        rd(A_FLAGS, v); check("R5 no flag without notify", v, 0);

        // R7: capture edges on a halted counter (value 2)
        wr(A_CCTL, 32'hD5);
        @(negedge clk);
        cap_in = 4'b1111;
        idle(6);
        rd(A_CAP_BASE + 5'd0, v); check("R7 rising capture", v, 2);
        rd(A_CAP_BASE + 5'd1, v); check("R7 rising ignored on falling lane", v, 0);
        rd(A_CAP_BASE + 5'd2, v); check("R7 both-edge capture", v, 2);
        rd(A_CAP_BASE + 5'd3, v); check("R7 disabled lane ignored", v, 0);
        rd(A_FLAGS, v); check("R7 capture flag only with notify", v, 32'h10);
        @(negedge clk);
        cap_in = 4'b0000;
        idle(6);
        rd(A_CAP_BASE + 5'd1, v); check("R7 falling capture", v, 2);

        // R8: event counting from capture input 3
        wr(A_FLAGS, 32'hFF);
        wr(A_CTRL, 32'd2);
        wr(A_MCTL, 32'd0);
        wr(A_MODE, 32'd13);
        wr(A_CTRL, 32'd1);
        pulse3(5);
        rd(A_COUNT, v); check("R8 rising edges counted", v, 5);
        rd(A_PSCNT, v); check("R8 prescale idle", v, 0);
        wr(A_CTRL, 32'd2);
        wr(A_MODE, 32'd15);
        wr(A_CTRL, 32'd1);
        pulse3(3);
        rd(A_COUNT, v); check("R8 both edges counted", v, 6);
        wr(A_CTRL, 32'd2);
        wr(A_MODE, 32'd14);
        wr(A_CTRL, 32'd1);
        pulse3(2);
        rd(A_COUNT, v); check("R8 falling edges counted", v, 2);

        // R2: disable freezes, hold clears
        wr(A_CTRL, 32'd2);
        wr(A_MODE, 32'd0);
        wr(A_PSLIM, 32'd0);
        wr(A_CTRL, 32'd1);
        idle(10);
        wr(A_CTRL, 32'd0);
        rd(A_COUNT, a);
        idle(10);
        rd(A_COUNT, b);
        check("R2 disabled counter frozen", b, a);
        check("R2 counter had advanced", 32'(a != 0), 1);
        wr(A_CTRL, 32'd2);
        rd(A_COUNT, v); check("R2 hold clears counter", v, 0);
        rd(A_PSCNT, v); check("R2 hold clears prescale", v, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule